// File: doc/BRIEF.md
# Age-Ordered Deflection Output Allocator

This block chooses, every cycle, an output link for each flit arriving at a router in a two-dimensional mesh that has no flit storage. Up to four flits arrive, one per mesh side. Each carries a valid bit, a 4-bit age stamp and a full destination coordinate. A flit can never be held back, so the allocator must send every valid flit out on a distinct link in the same cycle. Flits are served one after another, oldest first. Each flit takes a direction that brings it closer to its destination when such a direction is still free. If none is free, the flit is pushed onto a spare link and marked as deflected.

A static mode input selects how many directions a flit may ask for. In single-direction mode a flit asks only for the X-first, then-Y route. In multi-direction mode it asks for every direction that shortens its path, and X is tried before Y. Links that would leave the mesh are never granted. A flit addressed to the local node is ejected. Only one flit can be ejected per cycle, and any further local flits in that cycle are deflected. The results are registered, so the decision for the headers presented at one clock edge appears on the outputs after that edge.

Top module: `defl_out_alloc`

## Requirements
- R1: grant_o and deflect_o are registered. An active-low asynchronous reset clears both to zero, and while reset is held they stay zero whatever the inputs are. Otherwise the outputs after a clock edge reflect the inputs sampled at that edge.
- R2: Slice i of grant_o is grant_o[5*i+4:5*i]. Input ports are N=0, E=1, S=2, W=3. In the slice, bit 0 grants North (y+1), bit 1 East (x+1), bit 2 South (y-1), bit 3 West (x-1) and bit 4 local ejection. A valid input gets exactly one bit set. An invalid input gets an all-zero slice and deflect_o[i]=0.
- R3: No output bit position is granted to more than one input in the same cycle.
- R4: Flits are allocated one at a time in age order. Flit a is older than flit b when (a-b) mod 16 lies in 1..7. When neither flit is older than the other, the lower port index goes first. The ages of the valid inputs in one cycle are assumed to lie within a span of 7.
- R5: With mdr_mode_i=0, a flit whose dst_x differs from loc_x asks only for East (if dst_x>loc_x) or West. Otherwise it asks only for North (if dst_y>loc_y) or South.
- R6: With mdr_mode_i=1, a flit asks for both its productive X direction and its productive Y direction. It takes the X one if that is free, else the Y one.
- R7: A flit that finds none of its requested directions free takes the lowest-indexed free link (N, E, S, W order) and has its deflect_o bit set. A flit that gets a requested direction or is ejected has deflect_o clear.
- R8: No link that leaves the mesh is granted: North when loc_y=MESH_Y-1, South when loc_y=0, East when loc_x=MESH_X-1, West when loc_x=0. Inputs from such a side are assumed invalid.
- R9: A flit whose destination equals (loc_x, loc_y) gets the ejection bit if no older flit was ejected in that cycle. Otherwise it is deflected to a network link as in R7.
- R10: The oldest valid flit always gets a productive direction, or ejection, whenever it has one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mdr_mode_i | input | 1 | 1: request every productive direction; 0: X-then-Y single direction |
| loc_x_i | input | COORD_W | Local X coordinate (static) |
| loc_y_i | input | COORD_W | Local Y coordinate (static) |
| flit_valid_i | input | 4 | Per-input-port valid, bit i = port i |
| flit_age_i | input | 4*AGE_W | Per-port age stamp, port i at [AGE_W*i +: AGE_W] |
| flit_dst_x_i | input | 4*COORD_W | Per-port destination X |
| flit_dst_y_i | input | 4*COORD_W | Per-port destination Y |
| grant_o | output | 20 | Per-port one-hot output grant, 5 bits per port |
| deflect_o | output | 4 | Per-port deflection flag |

## Verification
Ejection and deflection can happen in the same cycle. This occurs when two flits addressed to the local node arrive together: the older one takes the ejection bit and the younger one must be pushed onto the lowest free network link. Age arbitration and the mesh-edge rule also meet at corner routers, where only two links remain and a contended flit has just one legal escape. The bench provokes both with directed headers at the centre and at corners, and with exhaustive valid-mask sweeps at the corners and an edge. Each result is compared with an independently computed sequential oldest-first allocation, and the bench also checks completeness, uniqueness and productivity for the oldest flit.

// File: rtl/dfl_pkg.sv
package dfl_pkg;
  localparam int NUM_LINK = 4;
  localparam int NUM_OUT  = NUM_LINK + 1;
  localparam int P_N = 0;
  localparam int P_E = 1;
  localparam int P_S = 2;
  localparam int P_W = 3;
  localparam int P_L = 4;

  typedef logic [NUM_LINK-1:0] link_vec_t;
  typedef logic [NUM_OUT-1:0]  out_vec_t;
endpackage

// File: rtl/dfl_route_req.sv
module dfl_route_req
  import dfl_pkg::*;
#(
  parameter int COORD_W = 3
) (
  input  logic               mdr_i,
  input  logic [COORD_W-1:0] loc_x_i,
  input  logic [COORD_W-1:0] loc_y_i,
  input  logic [COORD_W-1:0] dst_x_i,
  input  logic [COORD_W-1:0] dst_y_i,
  output link_vec_t          first_o,
  output link_vec_t          second_o,
  output logic               local_o
);
  logic      x_ne, y_ne;
  link_vec_t x_dir, y_dir;

  always_comb begin
    x_ne  = (dst_x_i != loc_x_i);
    y_ne  = (dst_y_i != loc_y_i);
    x_dir = '0;
    y_dir = '0;
    if (x_ne) begin
      if (dst_x_i > loc_x_i) x_dir[P_E] = 1'b1;
      else                   x_dir[P_W] = 1'b1;
    end
    if (y_ne) begin
      if (dst_y_i > loc_y_i) y_dir[P_N] = 1'b1;
      else                   y_dir[P_S] = 1'b1;
    end
    local_o = !x_ne && !y_ne;
    // X first; the Y choice is a fallback only in multi-direction mode
    if (x_ne) begin
      first_o  = x_dir;
      second_o = mdr_i ? y_dir : '0;
    end else begin
      first_o  = y_dir;
      second_o = '0;
    end
  end
endmodule

// File: rtl/dfl_age_sort.sv
module dfl_age_sort #(
  parameter  int N     = 4,
  parameter  int AGE_W = 4,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]       valid_i,
  input  logic [N*AGE_W-1:0] age_i,
  output logic [N*IDX_W-1:0] order_o
);
  typedef struct packed {
    logic             v;
    logic [AGE_W-1:0] age;
    logic [IDX_W-1:0] idx;
  } key_t;

  function automatic logic older(input logic [AGE_W-1:0] a, input logic [AGE_W-1:0] b);
    logic [AGE_W-1:0] d;
    d = a - b;
    return (d != '0) && !d[AGE_W-1];
  endfunction

  // valid before invalid, then age, then port index
  function automatic logic first_of(input key_t a, input key_t b);
    if (a.v != b.v) return a.v;
    if (older(a.age, b.age)) return 1'b1;
    if (older(b.age, a.age)) return 1'b0;
    return a.idx < b.idx;
  endfunction

  key_t stg [0:N][0:N-1];

  // odd-even transposition network, N stages
  for (genvar i = 0; i < N; i++) begin : g_in
    assign stg[0][i] = '{v: valid_i[i], age: age_i[i*AGE_W +: AGE_W], idx: IDX_W'(i)};
  end

  for (genvar s = 0; s < N; s++) begin : g_stage
    for (genvar i = 0; i < N; i++) begin : g_pos
      localparam bit LO = ((i % 2) == (s % 2)) && (i + 1 < N);
      localparam bit HI = ((i % 2) != (s % 2)) && (i > 0);
      if (LO) begin : g_lo
        assign stg[s+1][i] = first_of(stg[s][i+1], stg[s][i]) ? stg[s][i+1] : stg[s][i];
      end else if (HI) begin : g_hi
        assign stg[s+1][i] = first_of(stg[s][i], stg[s][i-1]) ? stg[s][i-1] : stg[s][i];
      end else begin : g_pass
        assign stg[s+1][i] = stg[s][i];
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_out
    assign order_o[i*IDX_W +: IDX_W] = stg[N][i].idx;
  end
endmodule

// File: rtl/dfl_seq_alloc.sv
module dfl_seq_alloc
  import dfl_pkg::*;
#(
  parameter  int N     = NUM_LINK,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N*IDX_W-1:0]  order_i,
  input  logic [N-1:0]        valid_i,
  input  link_vec_t [N-1:0]   first_i,
  input  link_vec_t [N-1:0]   second_i,
  input  logic [N-1:0]        local_i,
  input  link_vec_t           present_i,
  output out_vec_t [N-1:0]    grant_o,
  output logic [N-1:0]        deflect_o
);
  always_comb begin
    link_vec_t        free_v;
    link_vec_t        pick;
    logic             ej_free;
    logic [IDX_W-1:0] id;
    grant_o   = '0;
    deflect_o = '0;
    free_v    = present_i;
    ej_free   = 1'b1;
    pick      = '0;
    for (int k = 0; k < N; k++) begin
      id = order_i[k*IDX_W +: IDX_W];
      if (valid_i[id]) begin
        if (local_i[id] && ej_free) begin
          grant_o[id][P_L] = 1'b1;
          ej_free          = 1'b0;
        end else begin
          if (|(first_i[id] & free_v)) begin
            pick = first_i[id] & free_v;
          end else if (|(second_i[id] & free_v)) begin
            pick = second_i[id] & free_v;
          end else begin
            pick          = free_v & (~free_v + 1'b1);
            deflect_o[id] = 1'b1;
          end
          grant_o[id][NUM_LINK-1:0] = pick;
          free_v = free_v & ~pick;
        end
      end
    end
  end
endmodule

// File: rtl/defl_out_alloc.sv
module defl_out_alloc
  import dfl_pkg::*;
#(
  parameter  int MESH_X  = 8,
  parameter  int MESH_Y  = 8,
  parameter  int AGE_W   = 4,
  localparam int COORD_W = $clog2((MESH_X > MESH_Y) ? MESH_X : MESH_Y),
  localparam int IDX_W   = $clog2(NUM_LINK)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         mdr_mode_i,
  input  logic [COORD_W-1:0]           loc_x_i,
  input  logic [COORD_W-1:0]           loc_y_i,
  input  logic [NUM_LINK-1:0]          flit_valid_i,
  input  logic [NUM_LINK*AGE_W-1:0]    flit_age_i,
  input  logic [NUM_LINK*COORD_W-1:0]  flit_dst_x_i,
  input  logic [NUM_LINK*COORD_W-1:0]  flit_dst_y_i,
  output logic [NUM_LINK*NUM_OUT-1:0]  grant_o,
  output logic [NUM_LINK-1:0]          deflect_o
);
  link_vec_t                 present;
  link_vec_t [NUM_LINK-1:0]  first_w, second_w;
  logic [NUM_LINK-1:0]       local_w;
  logic [NUM_LINK*IDX_W-1:0] order_w;
  out_vec_t [NUM_LINK-1:0]   grant_d;
  logic [NUM_LINK-1:0]       defl_d;

  assign present[P_N] = (loc_y_i != COORD_W'(MESH_Y - 1));
  assign present[P_E] = (loc_x_i != COORD_W'(MESH_X - 1));
  assign present[P_S] = (loc_y_i != '0);
  assign present[P_W] = (loc_x_i != '0);

  for (genvar i = 0; i < NUM_LINK; i++) begin : g_req
    dfl_route_req #(.COORD_W(COORD_W)) u_req (
      .mdr_i    (mdr_mode_i),
      .loc_x_i  (loc_x_i),
      .loc_y_i  (loc_y_i),
      .dst_x_i  (flit_dst_x_i[i*COORD_W +: COORD_W]),
      .dst_y_i  (flit_dst_y_i[i*COORD_W +: COORD_W]),
      .first_o  (first_w[i]),
      .second_o (second_w[i]),
      .local_o  (local_w[i])
    );
  end

  dfl_age_sort #(.N(NUM_LINK), .AGE_W(AGE_W)) u_sort (
    .valid_i (flit_valid_i),
    .age_i   (flit_age_i),
    .order_o (order_w)
  );

  dfl_seq_alloc #(.N(NUM_LINK)) u_alloc (
    .order_i   (order_w),
    .valid_i   (flit_valid_i),
    .first_i   (first_w),
    .second_i  (second_w),
    .local_i   (local_w),
    .present_i (present),
    .grant_o   (grant_d),
    .deflect_o (defl_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_o   <= '0;
      deflect_o <= '0;
    end else begin
      grant_o   <= grant_d;
      deflect_o <= defl_d;
    end
  end
endmodule

// File: rtl/dfl_alloc_chk.sv
module dfl_alloc_chk #(
  parameter int MESH_X  = 8,
  parameter int MESH_Y  = 8,
  parameter int AGE_W   = 4,
  parameter int COORD_W = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [COORD_W-1:0] loc_x_i,
  input logic [COORD_W-1:0] loc_y_i,
  input logic [3:0]         flit_valid_i,
  input logic [4*AGE_W-1:0] flit_age_i,
  input logic [4*COORD_W-1:0] flit_dst_x_i,
  input logic [4*COORD_W-1:0] flit_dst_y_i,
  input logic [19:0]        grant_o,
  input logic [3:0]         deflect_o
);
  for (genvar i = 0; i < 4; i++) begin : g_port
    assert_one_grant_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flit_valid_i[i] |=> ($countones(grant_o[i*5 +: 5]) == 1));
    assert_idle_port_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !flit_valid_i[i] |=> (grant_o[i*5 +: 5] == 5'b0) && !deflect_o[i]);
    assert_eject_local_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grant_o[i*5+4] |-> ($past(flit_dst_x_i[i*COORD_W +: COORD_W]) == $past(loc_x_i)) &&
                         ($past(flit_dst_y_i[i*COORD_W +: COORD_W]) == $past(loc_y_i)));
  end

  for (genvar o = 0; o < 5; o++) begin : g_col
    assert_unique_out_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({grant_o[15+o], grant_o[10+o], grant_o[5+o], grant_o[o]}));
  end

  assert_no_north_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loc_y_i == COORD_W'(MESH_Y - 1)) |=> !(grant_o[0] | grant_o[5] | grant_o[10] | grant_o[15]));
  assert_no_east_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loc_x_i == COORD_W'(MESH_X - 1)) |=> !(grant_o[1] | grant_o[6] | grant_o[11] | grant_o[16]));
  assert_no_south_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loc_y_i == '0) |=> !(grant_o[2] | grant_o[7] | grant_o[12] | grant_o[17]));
  assert_no_west_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loc_x_i == '0) |=> !(grant_o[3] | grant_o[8] | grant_o[13] | grant_o[18]));

  logic unused_age;
  assign unused_age = ^flit_age_i;
endmodule

bind defl_out_alloc dfl_alloc_chk #(
  .MESH_X(MESH_X), .MESH_Y(MESH_Y), .AGE_W(AGE_W), .COORD_W(COORD_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .loc_x_i(loc_x_i), .loc_y_i(loc_y_i),
  .flit_valid_i(flit_valid_i), .flit_age_i(flit_age_i),
  .flit_dst_x_i(flit_dst_x_i), .flit_dst_y_i(flit_dst_y_i),
  .grant_o(grant_o), .deflect_o(deflect_o)
);

// File: tb/defl_out_alloc_tb.sv
`timescale 1ns/1ps
module defl_out_alloc_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mdr = 1'b0;
  logic [2:0]  lx = '0, ly = '0;
  logic [3:0]  v = '0;
  logic [15:0] ages = '0;
  logic [11:0] dxs = '0, dys = '0;
  logic [19:0] grant;
  logic [3:0]  defl;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [19:0] g;
    logic [3:0]  d;
    logic [3:0]  v;
    int          oldest;
    logic [4:0]  good;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  defl_out_alloc u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mdr_mode_i(mdr), .loc_x_i(lx), .loc_y_i(ly),
    .flit_valid_i(v), .flit_age_i(ages), .flit_dst_x_i(dxs), .flit_dst_y_i(dys),
    .grant_o(grant), .deflect_o(defl)
  );

  function automatic bit is_older(input logic [3:0] a, input logic [3:0] b);
    logic [3:0] df;
    df = a - b;
    return (df != 0) && (df < 8);
  endfunction

  // sequential oldest-first reference allocation
  function automatic exp_t model(input logic m, input logic [2:0] x, input logic [2:0] y,
                                 input logic [3:0] vv, input logic [15:0] ag,
                                 input logic [11:0] dx, input logic [11:0] dy);
    exp_t e;
    logic [3:0] free_v, taken;
    bit ej;
    int best, c0, c1, yc, ch;
    logic [2:0] ax, ay;
    e.g = '0; e.d = '0; e.v = vv; e.oldest = -1; e.good = '0; e.tag = "";
    free_v = {x != 0, y != 0, x != 7, y != 7};
    taken = '0; ej = 1;
    for (int step = 0; step < 4; step++) begin
      best = -1;
      for (int i = 0; i < 4; i++)
        if (vv[i] && !taken[i])
          if (best < 0 || is_older(ag[i*4 +: 4], ag[best*4 +: 4])) best = i;
      if (best >= 0) begin
        taken[best] = 1;
        ax = dx[best*3 +: 3]; ay = dy[best*3 +: 3];
        c0 = -1; c1 = -1; yc = -1;
        if (ay != y) yc = (ay > y) ? 0 : 2;
        if (ax != x) begin c0 = (ax > x) ? 1 : 3; if (m) c1 = yc; end
        else c0 = yc;
        if (step == 0) begin
          e.oldest = best;
          if (c0 >= 0) e.good[c0] = 1;
          if (c1 >= 0) e.good[c1] = 1;
          if (c0 < 0) e.good[4] = 1;
        end
        if (ax == x && ay == y && ej) begin
          e.g[best*5+4] = 1; ej = 0;
        end else begin
          ch = -1;
          if (c0 >= 0 && free_v[c0]) ch = c0;
          else if (c1 >= 0 && free_v[c1]) ch = c1;
          else begin
            for (int p = 3; p >= 0; p--) if (free_v[p]) ch = p;
            e.d[best] = 1;
          end
          if (ch >= 0) begin e.g[best*5+ch] = 1; free_v[ch] = 0; end
        end
      end
    end
    return e;
  endfunction

  task automatic drive(input logic m, input logic [2:0] x, input logic [2:0] y,
                       input logic [3:0] vv, input logic [15:0] ag,
                       input logic [11:0] dx, input logic [11:0] dy, input string tag);
    exp_t e;
    @(negedge clk);
    mdr = m; lx = x; ly = y; v = vv; ages = ag; dxs = dx; dys = dy;
    e = model(m, x, y, vv, ag, dx, dy);
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  // monitor: scoreboard compare one edge after each drive
  initial begin
    exp_t e;
    int cnt;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        check(grant == e.g && defl == e.d, e.tag, {8'h0, defl, grant}, {8'h0, e.d, e.g});
        for (int i = 0; i < 4; i++) begin
          cnt = $countones(grant[i*5 +: 5]);
          if (e.v[i]) check(cnt == 1, "R2 one grant", cnt, 1);
          else check(cnt == 0 && !defl[i], "R2 idle port", {defl[i], grant[i*5 +: 5]}, 0);
        end
        for (int o = 0; o < 5; o++) begin
          cnt = grant[o] + grant[5+o] + grant[10+o] + grant[15+o];
          check(cnt <= 1, "R3 unique output", cnt, 1);
        end
        if (e.oldest >= 0 && e.good != 0)
          check((grant[e.oldest*5 +: 5] & e.good) != 0, "R10 oldest productive",
                grant[e.oldest*5 +: 5], e.good);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  function automatic logic [11:0] pk(input int a, input int b, input int c, input int d);
    return {3'(d), 3'(c), 3'(b), 3'(a)};
  endfunction

  function automatic logic [15:0] pa(input int a, input int b, input int c, input int d);
    return {4'(d), 4'(c), 4'(b), 4'(a)};
  endfunction

  initial begin
    logic [3:0] pres, vv;
    logic [15:0] ag;
    logic [11:0] dx, dy;
    int base;
    int locs [5][2] = '{'{0,0}, '{7,7}, '{0,7}, '{3,3}, '{5,0}};

    // R1: reset holds outputs at zero despite active inputs
    v = 4'hF; lx = 3; ly = 3; dxs = pk(6,6,0,0); dys = pk(6,0,6,0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(grant == 0 && defl == 0, "R1 reset state", {defl, grant}, 0);
    v = 0; rst_n = 1'b1;
    @(negedge clk);
    check(grant == 0 && defl == 0, "R1 idle after reset", {defl, grant}, 0);

    // R5: single flit, X first
    drive(0, 3, 3, 4'b1000, pa(0,0,0,2), pk(0,0,0,6), pk(0,0,0,5), "R5 x-first east");
    drive(0, 3, 3, 4'b0001, pa(1,0,0,0), pk(3,0,0,0), pk(0,0,0,0), "R5 y south");
    // R4/R7: both want east, older west port wins, north deflected
    drive(0, 3, 3, 4'b1001, pa(3,0,0,5), pk(5,0,0,6), pk(3,0,0,3), "R4 R7 age wins");
    // R4: equal ages, lower port index first
    drive(0, 3, 3, 4'b0110, pa(0,4,4,0), pk(0,3,3,0), pk(0,6,6,0), "R4 tie by index");
    // R4: wraparound, 1 is older than 15
    drive(0, 3, 3, 4'b0011, pa(15,1,0,0), pk(1,1,0,0), pk(3,3,0,0), "R4 wraparound");
    // R6 vs R5: younger wants NE after older takes E
    drive(1, 3, 3, 4'b1001, pa(2,0,0,6), pk(6,0,0,6), pk(6,0,0,3), "R6 multi-direction");
    drive(0, 3, 3, 4'b1001, pa(2,0,0,6), pk(6,0,0,6), pk(6,0,0,3), "R5 R7 single deflects");
    // R9: two local flits, older ejects, younger deflected, in same cycle
    drive(0, 3, 3, 4'b0101, pa(2,0,5,0), pk(3,0,3,0), pk(3,0,3,0), "R9 R7 eject and deflect");
    // R8: corner (7,7), both local
    drive(0, 7, 7, 4'b1100, pa(0,0,1,3), pk(0,0,7,7), pk(0,0,7,7), "R8 R9 corner eject");
    // R8: corner (0,0), both heading out east
    drive(1, 0, 0, 4'b0011, pa(4,6,0,0), pk(5,5,0,0), pk(0,0,0,0), "R8 corner deflect");

    // R2 R3 R8: exhaustive valid masks at edges and centre
    foreach (locs[li]) begin
      pres = {locs[li][0] != 0, locs[li][1] != 0, locs[li][0] != 7, locs[li][1] != 7};
      for (int m = 0; m < 2; m++)
        for (int mask = 0; mask < 16; mask++)
          for (int rep = 0; rep < 3; rep++) begin
            vv = 4'(mask) & pres;
            base = $urandom_range(0, 15);
            for (int i = 0; i < 4; i++) begin
              ag[i*4 +: 4] = 4'(base + $urandom_range(0, 6));
              dx[i*3 +: 3] = 3'($urandom_range(0, 7));
              dy[i*3 +: 3] = 3'($urandom_range(0, 7));
            end
            drive(m[0], 3'(locs[li][0]), 3'(locs[li][1]), vv, ag, dx, dy, "R2 R8 sweep");
          end
    end

    // R4 R6 R10: random locations, ages near the wrap point
    for (int n = 0; n < 2000; n++) begin
      int x, y;
      x = $urandom_range(0, 7); y = $urandom_range(0, 7);
      pres = {x != 0, y != 0, x != 7, y != 7};
      vv = 4'($urandom_range(0, 15)) & pres;
      base = $urandom_range(10, 15);
      for (int i = 0; i < 4; i++) begin
        ag[i*4 +: 4] = 4'(base + $urandom_range(0, 6));
        dx[i*3 +: 3] = 3'(($urandom_range(0, 3) == 0) ? x : $urandom_range(0, 7));
        dy[i*3 +: 3] = 3'(($urandom_range(0, 3) == 0) ? y : $urandom_range(0, 7));
      end
      drive($urandom_range(0, 1) == 1, 3'(x), 3'(y), vv, ag, dx, dy, "R4 R6 R9 random");
    end

    @(negedge clk);
    v = 0;
    repeat (4) @(negedge clk);
    check(q.size() == 0, "R1 scoreboard drained", q.size(), 0);
    finish_run();
  end
endmodule